// File: doc/BRIEF.md
# Assignable Bandwidth Monitor Counter Bank

This block holds a bank of byte counters that software binds to traffic sources through one 64-bit configuration register. Each counter carries a committed binding: a 12-bit source ID, a flag that says whether the ID names a class of service or a monitoring tag, an event-type mask and a count-enable bit. Software may build a configuration over several register writes. The binding is applied to the counter named in the word only when a write sets the config-enable bit, and that commit also clears the counter.

On every cycle, the event port can present a monitoring tag, a class ID, an event-type vector and a byte count. Every enabled counter whose binding matches that event adds the byte count. A read port takes a counter ID and returns that counter's count one cycle later. A fault output flags register writes that are made while the feature is disabled, and writes that set reserved bits. Such a write changes no state.

Top module: `bwmon_bank`

## Requirements
- R1: After reset the configuration register reads 0, every counter is unbound, disabled and at 0, and the fault output is low.
- R2: A legal write with bit 63 (config-enable) at 0 loads the whole 64-bit word into the configuration register, which is visible on `cfg_o` the next cycle. It leaves every counter binding and count unchanged.
- R3: A legal write with bit 63 at 1 also binds the counter named by bits 52:48 to the word's fields and clears that counter to 0. An event in the same cycle is not added to that counter.
- R4: The binding takes bit 62 (count-enable) as the counter's enable. A counter committed with bit 62 at 0 never counts. One committed with bit 62 at 1 counts matching events.
- R5: A write while `feat_en_i` is low sets `fault_o` high in the next cycle and changes neither the configuration register nor any counter.
- R6: A write with any of bits 61:53 or 46:44 set sets `fault_o` high in the next cycle and is discarded completely. `fault_o` is low in the cycle after any cycle without a faulting write.
- R7: The source ID is taken from bits 43:32. When bit 47 is 1 it is compared with `evt_closid_i`. When bit 47 is 0 it is compared with `evt_rmid_i`.
- R8: A matching enabled counter adds `evt_bytes_i` only when the AND of its mask (bits 31:0) with `evt_type_i` is nonzero.
- R9: Counters are CNT_W bits wide (default 44) and wrap modulo 2^CNT_W.
- R10: `rd_data_o` gives the count of counter `rd_id_i` as it stands after the clock edge that samples `rd_id_i`. A read of a counter in the cycle it commits therefore returns 0.
- R11: Several counters bound to the same source all count the same event independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en_i | input | 1 | Feature enable; register writes fault while low |
| wr_en_i | input | 1 | Configuration register write strobe |
| wr_data_i | input | 64 | Configuration word |
| cfg_o | output | 64 | Current configuration register contents |
| fault_o | output | 1 | One-cycle pulse after an illegal write |
| evt_valid_i | input | 1 | Event present this cycle |
| evt_rmid_i | input | 12 | Monitoring tag of the event |
| evt_closid_i | input | 12 | Class-of-service ID of the event |
| evt_type_i | input | 32 | Event-type vector |
| evt_bytes_i | input | BYTE_W | Byte count of the event |
| rd_id_i | input | 5 | Counter to read |
| rd_data_o | output | CNT_W | Count of the addressed counter, one cycle later |

## Verification
The assertions assume that the inputs are stable around each rising edge and are never unknown once reset is released. The read-hold property also assumes that no counter changes when there is neither an event nor a write. The bench drives every input one time unit after the edge from a single process. It keeps all values two-state, and it restricts random source IDs to a small range so that random events actually match the random bindings.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;

    localparam int REG_W   = 64;
    localparam int CID_W   = 5;
    localparam int SRC_W   = 12;
    localparam int MASK_W  = 32;

    // Layout of the configuration word, most significant field first.
    typedef struct packed {
        logic              cfg_en;
        logic              cnt_en;
        logic [8:0]        rsv_hi;
        logic [CID_W-1:0]  cid;
        logic              is_class;
        logic [2:0]        rsv_lo;
        logic [SRC_W-1:0]  src;
        logic [MASK_W-1:0] mask;
    } cfg_word_t;

    // Committed binding of one counter.
    typedef struct packed {
        logic              cnt_en;
        logic              is_class;
        logic [SRC_W-1:0]  src;
        logic [MASK_W-1:0] mask;
    } bind_t;

endpackage

// File: rtl/bwmon_regif.sv
module bwmon_regif
    import bwmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_en_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] cfg_o,
    output logic             fault_o,
    output logic             commit_o,
    output logic [CID_W-1:0] commit_id_o,
    output bind_t            commit_bind_o
);

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic             fault;
    } regif_st_t;

    regif_st_t st_d, st_q;
    cfg_word_t word;
    logic      rsv_set;
    logic      legal;

    always_comb begin
        word     = cfg_word_t'(wr_data_i);
        rsv_set  = (|word.rsv_hi) | (|word.rsv_lo);
        legal    = wr_en_i & feat_en_i & ~rsv_set;

        st_d       = st_q;
        st_d.fault = wr_en_i & ~legal;
        if (legal) begin
            st_d.cfg = wr_data_i;
        end

        commit_o               = legal & word.cfg_en;
        commit_id_o            = word.cid;
        commit_bind_o.cnt_en   = word.cnt_en;
        commit_bind_o.is_class = word.is_class;
        commit_bind_o.src      = word.src;
        commit_bind_o.mask     = word.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o   = st_q.cfg;
    assign fault_o = st_q.fault;

endmodule

// File: rtl/bwmon_slot.sv
module bwmon_slot
    import bwmon_pkg::*;
#(
    parameter int CNT_W  = 44,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  bind_t             bind_i,
    input  logic              evt_valid_i,
    input  logic [SRC_W-1:0]  evt_rmid_i,
    input  logic [SRC_W-1:0]  evt_closid_i,
    input  logic [MASK_W-1:0] evt_type_i,
    input  logic [BYTE_W-1:0] evt_bytes_i,
    output logic [CNT_W-1:0]  cnt_next_o
);

    typedef struct packed {
        bind_t            bnd;
        logic [CNT_W-1:0] cnt;
    } slot_st_t;

    slot_st_t         st_d, st_q;
    logic [SRC_W-1:0] evt_src;
    logic             hit;

    always_comb begin
        evt_src = st_q.bnd.is_class ? evt_closid_i : evt_rmid_i;
        hit     = evt_valid_i & st_q.bnd.cnt_en
                & (st_q.bnd.src == evt_src)
                & (|(st_q.bnd.mask & evt_type_i));

        st_d = st_q;
        if (commit_i) begin
            st_d.bnd = bind_i;
            st_d.cnt = '0;
        end else if (hit) begin
            st_d.cnt = st_q.cnt + CNT_W'(evt_bytes_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_next_o = st_d.cnt;

endmodule

// File: rtl/bwmon_rdmux.sv
module bwmon_rdmux
    import bwmon_pkg::*;
#(
    parameter int NUM_CTR = 32,
    parameter int CNT_W   = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CID_W-1:0] rd_id_i,
    input  logic [CNT_W-1:0] cnt_i [NUM_CTR],
    output logic [CNT_W-1:0] rd_data_o
);

    typedef struct packed {
        logic [CNT_W-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d.data = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_id_i == CID_W'(i)) begin
                st_d.data = cnt_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;

endmodule

// File: rtl/bwmon_bank.sv
module bwmon_bank
    import bwmon_pkg::*;
#(
    parameter int NUM_CTR = 32,
    parameter int CNT_W   = 44,
    parameter int BYTE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_en_i,
    input  logic              wr_en_i,
    input  logic [63:0]       wr_data_i,
    output logic [63:0]       cfg_o,
    output logic              fault_o,
    input  logic              evt_valid_i,
    input  logic [11:0]       evt_rmid_i,
    input  logic [11:0]       evt_closid_i,
    input  logic [31:0]       evt_type_i,
    input  logic [BYTE_W-1:0] evt_bytes_i,
    input  logic [4:0]        rd_id_i,
    output logic [CNT_W-1:0]  rd_data_o
);

    logic             cmt;
    logic [CID_W-1:0] cmt_id;
    bind_t            cmt_bind;
    logic [CNT_W-1:0] cnt_next [NUM_CTR];

    bwmon_regif u_regif (
        .clk           (clk),
        .rst_n         (rst_n),
        .feat_en_i     (feat_en_i),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .cfg_o         (cfg_o),
        .fault_o       (fault_o),
        .commit_o      (cmt),
        .commit_id_o   (cmt_id),
        .commit_bind_o (cmt_bind)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
        logic slot_cmt;
        assign slot_cmt = cmt & (cmt_id == CID_W'(g));

        bwmon_slot #(
            .CNT_W  (CNT_W),
            .BYTE_W (BYTE_W)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .commit_i     (slot_cmt),
            .bind_i       (cmt_bind),
            .evt_valid_i  (evt_valid_i),
            .evt_rmid_i   (evt_rmid_i),
            .evt_closid_i (evt_closid_i),
            .evt_type_i   (evt_type_i),
            .evt_bytes_i  (evt_bytes_i),
            .cnt_next_o   (cnt_next[g])
        );
    end

    bwmon_rdmux #(
        .NUM_CTR (NUM_CTR),
        .CNT_W   (CNT_W)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_id_i   (rd_id_i),
        .cnt_i     (cnt_next),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/bwmon_bank_chk.sv
module bwmon_bank_chk #(
    parameter int CNT_W = 44
) (
    input logic             clk,
    input logic             rst_n,
    input logic             feat_en_i,
    input logic             wr_en_i,
    input logic [63:0]      wr_data_i,
    input logic [63:0]      cfg_o,
    input logic             fault_o,
    input logic             evt_valid_i,
    input logic [4:0]       rd_id_i,
    input logic [CNT_W-1:0] rd_data_o
);

    localparam logic [63:0] RSV_BITS = 64'h3FE0_7000_0000_0000;

    logic rsv_hit;
    logic good_wr;
    assign rsv_hit = |(wr_data_i & RSV_BITS);
    assign good_wr = wr_en_i & feat_en_i & ~rsv_hit;

    // R5
    feat_off_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !feat_en_i) |=> fault_o);

    // R5
    feat_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !feat_en_i) |=> $stable(cfg_o));

    // R6
    rsv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rsv_hit) |=> (fault_o && $stable(cfg_o)));

    // R6
    no_spurious_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> !fault_o);

    // R2
    stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && !wr_data_i[63]) |=> (cfg_o == $past(wr_data_i)));

    // R3
    commit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && wr_data_i[63] && (rd_id_i == wr_data_i[52:48]))
        |=> (rd_data_o == '0));

    // R10
    quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid_i && !wr_en_i && (rd_id_i == $past(rd_id_i)))
        |=> $stable(rd_data_o));

endmodule

bind bwmon_bank bwmon_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .feat_en_i   (feat_en_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .cfg_o       (cfg_o),
    .fault_o     (fault_o),
    .evt_valid_i (evt_valid_i),
    .rd_id_i     (rd_id_i),
    .rd_data_o   (rd_data_o)
);

// File: tb/bwmon_bank_tb.sv
module bwmon_bank_tb;

    localparam int NUM_CTR = 32;
    localparam int CNT_W   = 20;
    localparam int BYTE_W  = 16;
    localparam logic [63:0] RSV = 64'h3FE0_7000_0000_0000;
    localparam longint CMASK = (64'd1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              feat_en = 1'b1;
    logic              wr_en = 1'b0;
    logic [63:0]       wr_data = '0;
    logic [63:0]       cfg_o;
    logic              fault_o;
    logic              evt_valid = 1'b0;
    logic [11:0]       evt_rmid = '0;
    logic [11:0]       evt_closid = '0;
    logic [31:0]       evt_type = '0;
    logic [BYTE_W-1:0] evt_bytes = '0;
    logic [4:0]        rd_id = '0;
    logic [CNT_W-1:0]  rd_data;

    always #5 clk = ~clk;

    bwmon_bank #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .feat_en_i(feat_en), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .cfg_o(cfg_o), .fault_o(fault_o),
        .evt_valid_i(evt_valid), .evt_rmid_i(evt_rmid), .evt_closid_i(evt_closid),
        .evt_type_i(evt_type), .evt_bytes_i(evt_bytes), .rd_id_i(rd_id),
        .rd_data_o(rd_data)
    );

    // Behavioural reference model
    bit          m_en   [NUM_CTR];
    bit          m_cls  [NUM_CTR];
    bit [11:0]   m_src  [NUM_CTR];
    bit [31:0]   m_mask [NUM_CTR];
    longint      m_cnt  [NUM_CTR];
    bit [63:0]   m_cfg;
    bit          m_fault;
    longint      m_rd;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    task automatic chk(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [63:0] mk(bit cfg, bit cnt, int id, bit cls,
                                       int src, logic [31:0] mask);
        logic [63:0] w = '0;
        w[63]    = cfg;
        w[62]    = cnt;
        w[52:48] = id[4:0];
        w[47]    = cls;
        w[43:32] = src[11:0];
        w[31:0]  = mask;
        return w;
    endfunction

    task automatic model_step();
        bit             legal;
        bit [NUM_CTR-1:0] cm;
        int             id;
        bit [11:0]      es;
        cm      = '0;
        legal   = wr_en && feat_en && ((wr_data & RSV) == 64'd0);
        m_fault = wr_en && !legal;
        if (legal) begin
            m_cfg = wr_data;
            if (wr_data[63]) begin
                id         = int'(wr_data[52:48]);
                m_en[id]   = wr_data[62];
                m_cls[id]  = wr_data[47];
                m_src[id]  = wr_data[43:32];
                m_mask[id] = wr_data[31:0];
                m_cnt[id]  = 0;
                cm[id]     = 1'b1;
            end
        end
        if (evt_valid) begin
            for (int i = 0; i < NUM_CTR; i++) begin
                es = m_cls[i] ? evt_closid : evt_rmid;
                if (!cm[i] && m_en[i] && es == m_src[i] && (m_mask[i] & evt_type) != 0)
                    m_cnt[i] = (m_cnt[i] + longint'(evt_bytes)) & CMASK;
            end
        end
        m_rd = m_cnt[rd_id];
    endtask

    // One clock: update model from held inputs, then compare all outputs (R10 latency).
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        chk(fault_o == m_fault, {cur_req, " fault"}, longint'(fault_o), longint'(m_fault));
        chk(cfg_o == m_cfg, {cur_req, " cfg"}, longint'(cfg_o), longint'(m_cfg));
        chk(longint'(rd_data) == m_rd, {cur_req, " R10 read"}, longint'(rd_data), m_rd);
    endtask

    task automatic idle();
        wr_en = 1'b0;
        evt_valid = 1'b0;
    endtask

    task automatic wr(logic [63:0] w);
        wr_en = 1'b1;
        wr_data = w;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic ev(int rmid, int clos, logic [31:0] typ, int bytes);
        evt_valid  = 1'b1;
        evt_rmid   = rmid[11:0];
        evt_closid = clos[11:0];
        evt_type   = typ;
        evt_bytes  = bytes[BYTE_W-1:0];
        cyc();
        evt_valid  = 1'b0;
    endtask

    task automatic rd(int id);
        rd_id = id[4:0];
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_CTR; i++) begin
            m_en[i] = 0; m_cls[i] = 0; m_src[i] = 0; m_mask[i] = 0; m_cnt[i] = 0;
        end
        m_cfg = '0; m_fault = 0; m_rd = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        cyc();
        chk(cfg_o == 64'd0, "R1 cfg reset", longint'(cfg_o), 0);
        chk(fault_o == 1'b0, "R1 fault reset", longint'(fault_o), 0);
        chk(rd_data == '0, "R1 count reset", longint'(rd_data), 0);

        // R2: staging write leaves counter 3 unbound
        cur_req = "R2";
        rd_id = 5'd3;
        wr(mk(0, 1, 3, 0, 5, 32'h1));
        chk(cfg_o == mk(0, 1, 3, 0, 5, 32'h1), "R2 staged word", longint'(cfg_o),
            longint'(mk(0, 1, 3, 0, 5, 32'h1)));
        ev(5, 0, 32'h1, 77);
        cyc();
        chk(rd_data == '0, "R2 no binding from staging", longint'(rd_data), 0);

        // R4: commit without count-enable stays idle
        cur_req = "R4";
        wr(mk(1, 0, 3, 0, 5, 32'h1));
        ev(5, 0, 32'h1, 50);
        cyc();
        chk(rd_data == '0, "R4 idle counter", longint'(rd_data), 0);

        // R3/R7: commit with count-enable, tag match
        cur_req = "R3";
        wr(mk(1, 1, 3, 0, 5, 32'h1));
        ev(5, 0, 32'h1, 100);
        ev(5, 9, 32'h1, 200);
        cyc();
        chk(rd_data == 20'd300, "R7 tag match count", longint'(rd_data), 300);
        // R3: recommit while reading, with a matching event in the same cycle
        evt_valid = 1'b1; evt_rmid = 12'd5; evt_type = 32'h1; evt_bytes = 16'd40;
        wr(mk(1, 1, 3, 0, 5, 32'h1));
        idle();
        chk(rd_data == '0, "R3 commit clears and reads 0", longint'(rd_data), 0);

        // R7: class-based source
        cur_req = "R7";
        rd_id = 5'd7;
        wr(mk(1, 1, 7, 1, 9, 32'h0000_00F0));
        ev(9, 1, 32'h10, 11);
        ev(0, 9, 32'h10, 22);
        cyc();
        chk(rd_data == 20'd22, "R7 class match only", longint'(rd_data), 22);

        // R8: mask gating
        cur_req = "R8";
        ev(0, 9, 32'h0F, 33);
        ev(0, 9, 32'h80, 4);
        cyc();
        chk(rd_data == 20'd26, "R8 mask gate", longint'(rd_data), 26);

        // R11: two counters, same tag
        cur_req = "R11";
        wr(mk(1, 1, 10, 0, 20, 32'hFFFF_FFFF));
        wr(mk(1, 1, 11, 0, 20, 32'h2));
        ev(20, 0, 32'h2, 500);
        rd(10);
        chk(rd_data == 20'd500, "R11 first counter", longint'(rd_data), 500);
        rd(11);
        chk(rd_data == 20'd500, "R11 second counter", longint'(rd_data), 500);

        // R5: feature disabled
        cur_req = "R5";
        feat_en = 1'b0;
        wr(mk(1, 1, 11, 0, 21, 32'h2));
        chk(fault_o == 1'b1, "R5 fault raised", longint'(fault_o), 1);
        ev(20, 0, 32'h2, 5);
        feat_en = 1'b1;
        cyc();
        chk(rd_data == 20'd505, "R5 binding unchanged", longint'(rd_data), 505);

        // R6: reserved bits
        cur_req = "R6";
        wr(mk(1, 1, 11, 0, 21, 32'h2) | (64'd1 << 55));
        chk(fault_o == 1'b1, "R6 high reserved fault", longint'(fault_o), 1);
        wr(mk(0, 0, 0, 0, 0, 32'h0) | (64'd1 << 45));
        chk(fault_o == 1'b1, "R6 low reserved fault", longint'(fault_o), 1);
        cyc();
        chk(fault_o == 1'b0, "R6 fault clears", longint'(fault_o), 0);
        chk(rd_data == 20'd505, "R6 discarded write", longint'(rd_data), 505);

        // R9: wrap
        cur_req = "R9";
        rd_id = 5'd12;
        wr(mk(1, 1, 12, 0, 30, 32'h1));
        for (int k = 0; k < 17; k++) ev(30, 0, 32'h1, 65535);
        cyc();
        chk(rd_data == 20'd65519, "R9 wrap", longint'(rd_data), 65519);

        // Random mix, compared against the model every cycle (R2..R11)
        cur_req = "R10 random";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            feat_en = (r != 0);
            wr_en   = (r < 12);
            wr_data = mk(r < 8, $urandom_range(0, 3) != 0, int'($urandom_range(0, 31)),
                         $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)),
                         32'h1 << $urandom_range(0, 3));
            if (r == 5) wr_data[50 + 4] = 1'b1;
            evt_valid  = $urandom_range(0, 1) == 1;
            evt_rmid   = 12'($urandom_range(0, 3));
            evt_closid = 12'($urandom_range(0, 3));
            evt_type   = 32'($urandom_range(0, 15));
            evt_bytes  = 16'($urandom_range(0, 65535));
            rd_id      = 5'($urandom_range(0, 31));
            cyc();
        end
        idle();
        feat_en = 1'b1;
        cyc();

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule